// File: doc/BRIEF.md
# Arithmetic unit with overflow word

This block is the purely combinational 16-bit arithmetic and logic stage of a small word-oriented processor. Each cycle the surrounding datapath presents a 4-bit operation code, operand `a` (the current value of the destination) and operand `b` (the source value). The block returns the result word. It also returns a flag telling the datapath whether the result is written back, a flag telling it whether the overflow word must be replaced, the new overflow word, and a pass bit for the four conditional-test operations.

The overflow word is not a single carry bit. It is a full 16-bit word whose meaning depends on the operation:
- a carry of one for addition
- all ones on a borrow for subtraction
- the upper product half for multiplication
- the fractional quotient bits for division
- the bits pushed out of the word for the two shifts

Operand fetch, write-back, the overflow register itself and instruction timing belong to the datapath. The block holds no state and has no clock. Every operand and comparison is unsigned.

Top module: `ovf_alu`

## Requirements
- R1: Opcodes 0x1 (copy b), 0x9 (a AND b), 0xa (a OR b) and 0xb (a XOR b) give the stated result with `wr_en`=1 and `ovf_upd`=0.
- R2: Opcode 0x2 gives (a+b) mod 65536 with `ovf_upd`=1 and `ovf_new`=0x0001 when the true sum exceeds 0xffff, else 0x0000.
- R3: Opcode 0x3 gives (a-b) mod 65536 with `ovf_upd`=1 and `ovf_new`=0xffff when b>a, else 0x0000.
- R4: Opcode 0x4 gives the low 16 bits of the 32-bit product a*b in `res` and the high 16 bits in `ovf_new`, with `ovf_upd`=1.
- R5: Opcode 0x5 gives floor(a/b) in `res` and bits 15:0 of floor(a*65536/b) in `ovf_new`, with `ovf_upd`=1. When b=0, both are 0x0000.
- R6: Opcode 0x6 gives a mod b, or 0x0000 when b=0, with `wr_en`=1 and `ovf_upd`=0.
- R7: Opcode 0x7 forms the 32-bit value a shifted left by b. Its bits 15:0 go to `res` and bits 31:16 to `ovf_new`, with `ovf_upd`=1. Any b of 32 or more gives zero in both.
- R8: Opcode 0x8 forms a*65536 shifted right by b as a 32-bit value. Its bits 31:16 go to `res` and bits 15:0 to `ovf_new`, with `ovf_upd`=1. Any b of 32 or more gives zero in both.
- R9: `test_pass` is 1 exactly when the test holds:
  - for 0xc, a==b
  - for 0xd, a!=b
  - for 0xe, a>b (unsigned)
  - for 0xf, (a AND b)!=0
  
  For every other opcode `test_pass` is 0.
- R10: For the test opcodes 0xc to 0xf and for opcode 0x0, `wr_en`=0, `ovf_upd`=0 and `res`=0x0000.
- R11: Whenever `ovf_upd` is 0, `ovf_new` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code (0x0 means no arithmetic; 0x1 to 0xf as in the requirements) |
| a | input | 16 | Current destination value |
| b | input | 16 | Source value |
| res | output | 16 | Result word |
| wr_en | output | 1 | Result is to be written to the destination |
| ovf_upd | output | 1 | Overflow word is to be replaced by `ovf_new` |
| ovf_new | output | 16 | New overflow word |
| test_pass | output | 1 | Conditional test holds |

## Verification
The checker continuously enforces properties that relate outputs to inputs without recomputing them:
- the addition carry agrees with result wrap-around
- the subtraction word is only ever 0x0000 or 0xffff, and adding `b` back restores `a`
- the remainder stays below a non-zero divisor, and the quotient times the divisor never exceeds `a`
- division by zero yields zeros
- the tests never write
- a non-updated overflow word is zero

The exact overflow contents cannot be shown by such invariants. These are the product high half, the fractional division bits, the bits shifted out at amounts 16 and 31 and at amounts of 32 or more, and the unsigned ordering at the sign boundary. The bench's vector table and its computed shift and multiply sweeps cover them.

// File: rtl/ovf_alu_pkg.sv
package ovf_alu_pkg;
  typedef enum logic [3:0] {
    OP_NONE = 4'h0,
    OP_COPY = 4'h1,
    OP_ADD  = 4'h2,
    OP_SUB  = 4'h3,
    OP_MUL  = 4'h4,
    OP_DIV  = 4'h5,
    OP_MOD  = 4'h6,
    OP_SHL  = 4'h7,
    OP_SHR  = 4'h8,
    OP_AND  = 4'h9,
    OP_OR   = 4'ha,
    OP_XOR  = 4'hb,
    OP_TEQ  = 4'hc,
    OP_TNE  = 4'hd,
    OP_TGT  = 4'he,
    OP_TBIT = 4'hf
  } alu_op_e;
endpackage

// File: rtl/ovf_alu_addsub.sv
module ovf_alu_addsub #(
  parameter int W = 16
) (
  input  logic         subtract,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic [W-1:0] ovf
);
  logic [W:0] sum_x;

  always_comb begin
    if (subtract) sum_x = {1'b0, a} - {1'b0, b};
    else          sum_x = {1'b0, a} + {1'b0, b};
    res = sum_x[W-1:0];
    if (!sum_x[W])     ovf = '0;
    else if (subtract) ovf = '1;
    else               ovf = {{(W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/ovf_alu_muldiv.sv
module ovf_alu_muldiv #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] mul_lo,
  output logic [W-1:0] mul_hi,
  output logic [W-1:0] quo,
  output logic [W-1:0] quo_frac,
  output logic [W-1:0] rem
);
  localparam int W2 = 2 * W;

  logic [W2-1:0] prod;
  logic [W2-1:0] frac_q;
  logic          b_zero;

  assign b_zero = (b == '0);
  assign prod   = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign mul_lo = prod[W-1:0];
  assign mul_hi = prod[W2-1:W];

  always_comb begin
    if (b_zero) begin
      quo    = '0;
      rem    = '0;
      frac_q = '0;
    end else begin
      quo    = a / b;
      rem    = a % b;
      frac_q = {a, {W{1'b0}}} / {{W{1'b0}}, b};
    end
    quo_frac = frac_q[W-1:0];
  end
endmodule

// File: rtl/ovf_alu_shift.sv
module ovf_alu_shift #(
  parameter int W = 16
) (
  input  logic         to_right,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic [W-1:0] ovf
);
  localparam int W2 = 2 * W;
  localparam int SB = $clog2(W2);

  logic [W2-1:0] lstg [SB+1];
  logic [W2-1:0] rstg [SB+1];
  logic          too_far;

  assign lstg[0] = {{W{1'b0}}, a};
  assign rstg[0] = {a, {W{1'b0}}};
  assign too_far = |b[W-1:SB];

  for (genvar k = 0; k < SB; k++) begin : g_stage
    assign lstg[k+1] = b[k] ? (lstg[k] << (1 << k)) : lstg[k];
    assign rstg[k+1] = b[k] ? (rstg[k] >> (1 << k)) : rstg[k];
  end

  always_comb begin
    if (too_far) begin
      res = '0;
      ovf = '0;
    end else if (to_right) begin
      res = rstg[SB][W2-1:W];
      ovf = rstg[SB][W-1:0];
    end else begin
      res = lstg[SB][W-1:0];
      ovf = lstg[SB][W2-1:W];
    end
  end
endmodule

// File: rtl/ovf_alu_logic.sv
module ovf_alu_logic #(
  parameter int W = 16
) (
  input  ovf_alu_pkg::alu_op_e op,
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  output logic [W-1:0]         res,
  output logic                 pass
);
  import ovf_alu_pkg::*;

  always_comb begin
    unique case (op)
      OP_COPY: res = b;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = '0;
    endcase
    unique case (op)
      OP_TEQ:  pass = (a == b);
      OP_TNE:  pass = (a != b);
      OP_TGT:  pass = (a > b);
      OP_TBIT: pass = |(a & b);
      default: pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/ovf_alu.sv
module ovf_alu #(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         wr_en,
  output logic         ovf_upd,
  output logic [W-1:0] ovf_new,
  output logic         test_pass
);
  import ovf_alu_pkg::*;

  alu_op_e       opc;
  logic [W-1:0]  as_res, as_ovf;
  logic [W-1:0]  mul_lo, mul_hi, quo, quo_frac, rem;
  logic [W-1:0]  sh_res, sh_ovf;
  logic [W-1:0]  lg_res;

  assign opc = alu_op_e'(op);

  ovf_alu_addsub #(.W(W)) u_addsub (
    .subtract (opc == OP_SUB),
    .a        (a),
    .b        (b),
    .res      (as_res),
    .ovf      (as_ovf)
  );

  ovf_alu_muldiv #(.W(W)) u_muldiv (
    .a        (a),
    .b        (b),
    .mul_lo   (mul_lo),
    .mul_hi   (mul_hi),
    .quo      (quo),
    .quo_frac (quo_frac),
    .rem      (rem)
  );

  ovf_alu_shift #(.W(W)) u_shift (
    .to_right (opc == OP_SHR),
    .a        (a),
    .b        (b),
    .res      (sh_res),
    .ovf      (sh_ovf)
  );

  ovf_alu_logic #(.W(W)) u_logic (
    .op   (opc),
    .a    (a),
    .b    (b),
    .res  (lg_res),
    .pass (test_pass)
  );

  always_comb begin
    res     = '0;
    wr_en   = 1'b0;
    ovf_upd = 1'b0;
    ovf_new = '0;
    unique case (opc)
      OP_COPY, OP_AND, OP_OR, OP_XOR: begin
        res   = lg_res;
        wr_en = 1'b1;
      end
      OP_ADD, OP_SUB: begin
        res = as_res; wr_en = 1'b1; ovf_upd = 1'b1; ovf_new = as_ovf;
      end
      OP_MUL: begin
        res = mul_lo; wr_en = 1'b1; ovf_upd = 1'b1; ovf_new = mul_hi;
      end
      OP_DIV: begin
        res = quo; wr_en = 1'b1; ovf_upd = 1'b1; ovf_new = quo_frac;
      end
      OP_MOD: begin
        res = rem; wr_en = 1'b1;
      end
      OP_SHL, OP_SHR: begin
        res = sh_res; wr_en = 1'b1; ovf_upd = 1'b1; ovf_new = sh_ovf;
      end
      default: begin
        res = '0;
      end
    endcase
  end
endmodule

// File: rtl/ovf_alu_chk.sv
module ovf_alu_chk #(
  parameter int W = 16
) (
  input logic [3:0]   op,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [W-1:0] res,
  input logic         wr_en,
  input logic         ovf_upd,
  input logic [W-1:0] ovf_new,
  input logic         test_pass
);
  localparam int W2 = 2 * W;

  always_comb begin
    if (op == 4'h1 || op == 4'h9 || op == 4'ha || op == 4'hb) begin
      // R1
      logic_no_ovf_chk: assert (wr_en && !ovf_upd);
    end
    if (op == 4'h2) begin
      // R2
      add_carry_chk: assert (ovf_upd && (ovf_new == ((res < a) ? W'(1) : W'(0))));
    end
    if (op == 4'h3) begin
      // R3
      sub_borrow_chk: assert (ovf_upd && (ovf_new == '0 || ovf_new == '1) && (W'(res + b) == a));
    end
    if (op == 4'h4 && b == W'(1)) begin
      // R4
      mul_unit_chk: assert (res == a && ovf_new == '0);
    end
    if (op == 4'h5) begin
      // R5
      div_bound_chk: assert ((b == '0) ? (res == '0 && ovf_new == '0)
                             : (({{W{1'b0}}, res} * {{W{1'b0}}, b}) <= W2'(a)));
    end
    if (op == 4'h6) begin
      // R6
      mod_range_chk: assert (wr_en && !ovf_upd && ((b == '0) ? (res == '0) : (res < b)));
    end
    if ((op == 4'h7 || op == 4'h8) && b >= W'(W2)) begin
      // R7
      shift_far_chk: assert (res == '0 && ovf_new == '0 && ovf_upd);
    end
    if (op == 4'hc) begin
      // R9
      test_eq_chk: assert (test_pass == (a == b));
    end
    if (op == 4'h0 || op >= 4'hc) begin
      // R10
      no_write_chk: assert (!wr_en && !ovf_upd && res == '0);
    end
    if (op < 4'hc) begin
      // R9
      pass_idle_chk: assert (!test_pass);
    end
    if (!ovf_upd) begin
      // R11
      ovf_quiet_chk: assert (ovf_new == '0);
    end
  end
endmodule

bind ovf_alu ovf_alu_chk #(.W(W)) u_chk (
  .op        (op),
  .a         (a),
  .b         (b),
  .res       (res),
  .wr_en     (wr_en),
  .ovf_upd   (ovf_upd),
  .ovf_new   (ovf_new),
  .test_pass (test_pass)
);

// File: tb/ovf_alu_test.sv
module ovf_alu_test;
  typedef struct packed {
    logic [3:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] res;
    logic        wr;
    logic        upd;
    logic [15:0] ovf;
    logic        pass;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VT [NV] = '{
    '{4'h1, 16'h1234, 16'habcd, 16'habcd, 1'b1, 1'b0, 16'h0000, 1'b0}, // R1
    '{4'h9, 16'hf0f0, 16'hff00, 16'hf000, 1'b1, 1'b0, 16'h0000, 1'b0}, // R1
    '{4'ha, 16'hf0f0, 16'h0f00, 16'hfff0, 1'b1, 1'b0, 16'h0000, 1'b0}, // R1
    '{4'hb, 16'hffff, 16'h0f0f, 16'hf0f0, 1'b1, 1'b0, 16'h0000, 1'b0}, // R1
    '{4'h2, 16'hffff, 16'h0002, 16'h0001, 1'b1, 1'b1, 16'h0001, 1'b0}, // R2
    '{4'h2, 16'h1234, 16'h1111, 16'h2345, 1'b1, 1'b1, 16'h0000, 1'b0}, // R2
    '{4'h3, 16'h0005, 16'h0007, 16'hfffe, 1'b1, 1'b1, 16'hffff, 1'b0}, // R3
    '{4'h3, 16'h0030, 16'h0020, 16'h0010, 1'b1, 1'b1, 16'h0000, 1'b0}, // R3
    '{4'h4, 16'h1000, 16'h0100, 16'h0000, 1'b1, 1'b1, 16'h0010, 1'b0}, // R4
    '{4'h4, 16'hffff, 16'hffff, 16'h0001, 1'b1, 1'b1, 16'hfffe, 1'b0}, // R4
    '{4'h5, 16'h0007, 16'h0002, 16'h0003, 1'b1, 1'b1, 16'h8000, 1'b0}, // R5
    '{4'h5, 16'h0005, 16'h0000, 16'h0000, 1'b1, 1'b1, 16'h0000, 1'b0}, // R5
    '{4'h6, 16'h0007, 16'h0003, 16'h0001, 1'b1, 1'b0, 16'h0000, 1'b0}, // R6
    '{4'h6, 16'h1234, 16'h0000, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0}, // R6
    '{4'h7, 16'h0004, 16'h0004, 16'h0040, 1'b1, 1'b1, 16'h0000, 1'b0}, // R7
    '{4'h7, 16'h8001, 16'h0001, 16'h0002, 1'b1, 1'b1, 16'h0001, 1'b0}, // R7
    '{4'h7, 16'hffff, 16'h0020, 16'h0000, 1'b1, 1'b1, 16'h0000, 1'b0}, // R7
    '{4'h7, 16'h00ff, 16'h0010, 16'h0000, 1'b1, 1'b1, 16'h00ff, 1'b0}, // R7
    '{4'h8, 16'h0003, 16'h0001, 16'h0001, 1'b1, 1'b1, 16'h8000, 1'b0}, // R8
    '{4'h8, 16'hff00, 16'h0010, 16'h0000, 1'b1, 1'b1, 16'hff00, 1'b0}, // R8
    '{4'h8, 16'hffff, 16'h0040, 16'h0000, 1'b1, 1'b1, 16'h0000, 1'b0}, // R8
    '{4'hc, 16'h0005, 16'h0005, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1}, // R9
    '{4'hd, 16'h0005, 16'h0005, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0}, // R9
    '{4'he, 16'h8000, 16'h7fff, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1}, // R9
    '{4'he, 16'h0001, 16'h0001, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0}, // R9
    '{4'hf, 16'h0f00, 16'h00f0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0}, // R9
    '{4'hf, 16'h0f00, 16'h0100, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1}, // R9
    '{4'h0, 16'h0001, 16'h0001, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0}, // R10
    '{4'hd, 16'h1234, 16'h4321, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1}  // R10
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'h0;
  logic [15:0] a = '0, b = '0;
  logic [15:0] res, ovf_new;
  logic        wr_en, ovf_upd, test_pass;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ovf_alu uut (
    .op(op), .a(a), .b(b), .res(res), .wr_en(wr_en),
    .ovf_upd(ovf_upd), .ovf_new(ovf_new), .test_pass(test_pass)
  );

  task automatic check(input string tag, input logic [50:0] got, input logic [50:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s op=%h a=%h b=%h got=%h exp=%h", tag, op, a, b, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    op = o; a = x; b = y;
    #2;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R10: idle state with opcode 0 writes nothing
    apply(4'h0, 16'h0000, 16'h0000);
    check("R10 idle", {res, wr_en, ovf_upd, ovf_new, test_pass}, 51'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VT[i].op, VT[i].a, VT[i].b);
      check($sformatf("R%0s vec%0d", "-", i),
            {res, wr_en, ovf_upd, ovf_new, test_pass},
            {VT[i].res, VT[i].wr, VT[i].upd, VT[i].ovf, VT[i].pass});
    end

    // R7 sweep: left shift of a fixed pattern by every amount up to 40
    for (int s = 0; s <= 40; s++) begin
      logic [31:0] e;
      e = (s >= 32) ? 32'h0 : (32'h0000_b6d3 << s);
      apply(4'h7, 16'hb6d3, 16'(s));
      check("R7 shl sweep", {res, ovf_new}, {e[15:0], e[31:16]});
    end

    // R8 sweep: right shift of a fixed pattern by every amount up to 40
    for (int s = 0; s <= 40; s++) begin
      logic [31:0] e;
      e = (s >= 32) ? 32'h0 : (32'hb6d3_0000 >> s);
      apply(4'h8, 16'hb6d3, 16'(s));
      check("R8 shr sweep", {res, ovf_new}, {e[31:16], e[15:0]});
    end

    // R4 sweep: products of varied operands
    for (int k = 0; k < 16; k++) begin
      logic [15:0] x, y;
      logic [31:0] p;
      x = 16'(k * 16'h1357 + 16'h0ace);
      y = 16'(k * 16'h2468 + 16'h0003);
      p = 32'(x) * 32'(y);
      apply(4'h4, x, y);
      check("R4 mul sweep", {res, ovf_new, ovf_upd}, {p[15:0], p[31:16], 1'b1});
    end

    // R5 sweep: quotient and fractional bits
    for (int k = 1; k < 12; k++) begin
      logic [15:0] x, y;
      logic [31:0] f;
      x = 16'(k * 16'h0fed + 16'h0011);
      y = 16'(k * 16'h0123);
      f = {x, 16'h0000} / 32'(y);
      apply(4'h5, x, y);
      check("R5 div sweep", {res, ovf_new}, {x / y, f[15:0]});
    end

    // R11: a non-updating opcode following an updating one reports zero overflow
    apply(4'h4, 16'hffff, 16'hffff);
    apply(4'h6, 16'hffff, 16'hffff);
    check("R11 quiet ovf", {ovf_upd, ovf_new, res}, {1'b0, 16'h0000, 16'h0000});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule